// File: doc/BRIEF.md
# Parallel Fixed-Priority Arbiter

This block picks one winner from a set of simultaneous requests within a single combinational pass. The lowest-numbered line that is asserting always wins. Bit 0 of the request vector carries the top priority and bit N-1 carries the lowest. The block drives three outputs:

- a one-hot grant vector,
- a flag that says some request won,
- the binary number of the winning line.

The arbitration core can be built in one of three interchangeable structures, chosen by a parameter:

- a parallel chain that masks each request against all lower requests;
- an incrementer form that inverts the request vector, adds one and ANDs the sum with the requests;
- a binary tree of two-input max-selection nodes that carries the winner's index up to the root.

All three forms give identical outputs. The selector only trades logic depth against area and routing.

The block contains no state. It is meant to sit inside a clocked pipeline stage owned by the caller, for example in front of a shared resource. There the grant steers a multiplexer, and the index or flag goes into the next register.

Top module: `fixed_prio_arb`

## Requirements
- R1: Grant bit i is high only when request i is high and every request with a lower index is low (bit 0 has the highest priority).
- R2: With N=8 and request vector 8'b01100100, the grant is 8'b00000100 and the index is 2.
- R3: At most one grant bit is high at any time, for every request pattern.
- R4: The any-grant output is high exactly when at least one request bit is high.
- R5: When a grant is issued, the index output holds the binary position of the single high grant bit.
- R6: With an all-zero request vector, the grant is all zeros, any-grant is low and the index is zero, in every form (the incrementer's carry out is dropped).
- R7: Whenever at least one request is high, some request is granted.
- R8: The chain form (FORM=ARB_CHAIN), the incrementer form (FORM=ARB_ADDER) and the tree form (FORM=ARB_TREE) give identical grant, any-grant and index for every request pattern.
- R9: A width N that is not a power of two (for example N=5) works in every form; the tree pads the missing leaves with zero-valued requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req | input | N | Request lines; bit 0 has the highest priority |
| grant | output | N | One-hot (or all-zero) grant vector |
| any_grant | output | 1 | High when some request is granted |
| grant_idx | output | $clog2(N) | Binary index of the granted line, zero when idle |

## Verification
The checks assume only that `req` is a settled, two-valued vector. Because the block is purely combinational, every request pattern is legal and no ordering between patterns matters. The bench changes `req` on the falling clock edge and samples the outputs one nanosecond later, so the comparisons never see intermediate values. For N=8 and N=5 it walks the complete request space and drives every form with the same vector, so the checks cover all inputs of both widths.

// File: rtl/arb_pkg.sv
// Package: shared types for the fixed-priority arbiter family.
// Assumes nothing; holds only the selector for the core structure.
package arb_pkg;

    // Selects which equivalent structure computes the grant.
    typedef enum logic [1:0] {
        ARB_CHAIN = 2'd0,
        ARB_ADDER = 2'd1,
        ARB_TREE  = 2'd2
    } arb_form_e;

endpackage

// File: rtl/prio_chain_core.sv
// Module: prio_chain_core
// Computes each grant bit in parallel as its request ANDed with the
// inverse of every lower-indexed request. Assumes N >= 2.
module prio_chain_core #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    // One masking term per position; bit 0 passes its request straight through.
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == 0) begin : g_top
            assign grant[i] = req[i];
        end else begin : g_rest
            assign grant[i] = req[i] & ~(|req[i-1:0]);
        end
    end

endmodule

// File: rtl/prio_adder_core.sv
// Module: prio_adder_core
// Isolates the lowest set request bit by adding one to the inverted
// request vector and ANDing the sum with the requests. The carry out
// is dropped, so an all-zero request vector gives an all-zero grant.
// Assumes N >= 2.
module prio_adder_core #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    logic [N-1:0] inc_sum;

    // Increment of the inverted requests, truncated to N bits.
    assign inc_sum = (~req) + {{(N-1){1'b0}}, 1'b1};

    // Keep only the bit where the carry stopped.
    assign grant = req & inc_sum;

endmodule

// File: rtl/prio_tree_core.sv
// Module: prio_tree_core
// Binary tree of two-input max nodes over one-bit request values. Each
// node forwards the larger value and the index of its owner. On a tie it
// keeps the lower-indexed child, which yields fixed priority and index
// zero when idle. Missing leaves (N not a power of two) are zero-valued.
// Assumes N >= 2.
module prio_tree_core #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             win_val,
    output logic [IDX_W-1:0] win_idx
);

    localparam int LVLS  = $clog2(N);
    localparam int LEAFS = 1 << LVLS;
    localparam int NODES = 2 * LEAFS - 1;

    // Heap layout: node 0 is the root; the children of n are 2n+1 (lower) and 2n+2.
    logic [NODES-1:0] node_val;
    logic [IDX_W-1:0] node_idx [NODES];

    // Leaves: real requests first, then zero padding.
    for (genvar j = 0; j < LEAFS; j++) begin : g_leaf
        if (j < N) begin : g_real
            assign node_val[LEAFS-1+j] = req[j];
        end else begin : g_pad
            assign node_val[LEAFS-1+j] = 1'b0;
        end
        assign node_idx[LEAFS-1+j] = IDX_W'(j);
    end

    // Internal max nodes; a tie keeps the lower-indexed child.
    for (genvar n = 0; n < LEAFS - 1; n++) begin : g_node
        logic take_lo;
        assign take_lo     = node_val[2*n+1] | ~node_val[2*n+2];
        assign node_val[n] = take_lo ? node_val[2*n+1] : node_val[2*n+2];
        assign node_idx[n] = take_lo ? node_idx[2*n+1] : node_idx[2*n+2];
    end

    assign win_val = node_val[0];
    assign win_idx = node_idx[0];

endmodule

// File: rtl/onehot_to_index.sv
// Module: onehot_to_index
// Encodes a one-hot or all-zero vector into a binary index. Assumes at
// most one bit is set; an all-zero vector gives zero.
module onehot_to_index #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx
);

    // OR together the positions of all set bits.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) idx = idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/fixed_prio_arb.sv
// Module: fixed_prio_arb
// Combinational N-input fixed-priority arbiter. Request 0 has the highest
// priority. FORM picks the core structure; all forms agree on every output.
// Assumes N >= 2 and a settled request vector; holds no state.
module fixed_prio_arb
    import arb_pkg::*;
#(
    parameter int        N    = 8,
    parameter arb_form_e FORM = ARB_CHAIN,
    localparam int       IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic             any_grant,
    output logic [IDX_W-1:0] grant_idx
);

    if (FORM == ARB_TREE) begin : g_tree
        logic             t_val;
        logic [IDX_W-1:0] t_idx;

        // Tree gives value and index; the grant is decoded from the index.
        prio_tree_core #(.N(N), .IDX_W(IDX_W)) u_core (
            .req     (req),
            .win_val (t_val),
            .win_idx (t_idx)
        );

        assign grant     = t_val ? (N'(1) << t_idx) : '0;
        assign any_grant = t_val;
        assign grant_idx = t_idx;
    end else begin : g_flat
        logic [N-1:0] g_vec;

        // Flat forms give the one-hot grant; the index is encoded from it.
        if (FORM == ARB_ADDER) begin : g_adder
            prio_adder_core #(.N(N)) u_core (
                .req   (req),
                .grant (g_vec)
            );
        end else begin : g_chain
            prio_chain_core #(.N(N)) u_core (
                .req   (req),
                .grant (g_vec)
            );
        end

        onehot_to_index #(.N(N), .IDX_W(IDX_W)) u_enc (
            .vec (g_vec),
            .idx (grant_idx)
        );

        assign grant     = g_vec;
        assign any_grant = |g_vec;
    end

endmodule

// File: rtl/fixed_prio_arb_checker.sv
// Module: fixed_prio_arb_checker
// Port-level properties of the arbiter, checked as immediate assertions
// because the block has no clock. Assumes two-valued settled inputs.
module fixed_prio_arb_checker #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input logic [N-1:0]     req,
    input logic [N-1:0]     grant,
    input logic             any_grant,
    input logic [IDX_W-1:0] grant_idx
);

    // Evaluate every property whenever the ports settle.
    always_comb begin
        assert_grant_in_req_R1: assert ((grant & ~req) == '0)
            else $error("grant outside request set");
        assert_no_lower_req_R1: assert (((grant - N'(1)) & req) == '0 || grant == '0)
            else $error("lower request was skipped");
        assert_onehot_R3: assert ($onehot0(grant))
            else $error("more than one grant");
        assert_any_flag_R4: assert (any_grant == (req != '0))
            else $error("any-grant mismatch");
        assert_index_R5: assert (grant == '0 || grant == (N'(1) << grant_idx))
            else $error("index does not match grant");
        assert_idle_R6: assert (req != '0 || (grant == '0 && grant_idx == '0))
            else $error("idle outputs not zero");
        assert_work_conserving_R7: assert (req == '0 || grant != '0)
            else $error("requests but no grant");
    end

endmodule

bind fixed_prio_arb fixed_prio_arb_checker #(.N(N)) u_chk (
    .req       (req),
    .grant     (grant),
    .any_grant (any_grant),
    .grant_idx (grant_idx)
);

// File: tb/fixed_prio_arb_bench.sv
// Directed bench: every form, every request pattern, widths 8 and 5.
module fixed_prio_arb_bench;
    import arb_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [7:0] req8 = '0;
    logic [4:0] req5 = '0;

    logic [7:0] g_ch, g_ad, g_tr;
    logic       a_ch, a_ad, a_tr;
    logic [2:0] i_ch, i_ad, i_tr;
    logic [4:0] g5_ch, g5_ad, g5_tr;
    logic       a5_ch, a5_ad, a5_tr;
    logic [2:0] i5_ch, i5_ad, i5_tr;

    fixed_prio_arb #(.N(8), .FORM(ARB_CHAIN)) u_fixed_prio_arb (
        .req(req8), .grant(g_ch), .any_grant(a_ch), .grant_idx(i_ch));
    fixed_prio_arb #(.N(8), .FORM(ARB_ADDER)) u_adder8 (
        .req(req8), .grant(g_ad), .any_grant(a_ad), .grant_idx(i_ad));
    fixed_prio_arb #(.N(8), .FORM(ARB_TREE)) u_tree8 (
        .req(req8), .grant(g_tr), .any_grant(a_tr), .grant_idx(i_tr));
    fixed_prio_arb #(.N(5), .FORM(ARB_CHAIN)) u_chain5 (
        .req(req5), .grant(g5_ch), .any_grant(a5_ch), .grant_idx(i5_ch));
    fixed_prio_arb #(.N(5), .FORM(ARB_ADDER)) u_adder5 (
        .req(req5), .grant(g5_ad), .any_grant(a5_ad), .grant_idx(i5_ad));
    fixed_prio_arb #(.N(5), .FORM(ARB_TREE)) u_tree5 (
        .req(req5), .grant(g5_tr), .any_grant(a5_tr), .grant_idx(i5_tr));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference: lowest set bit wins; index 0 and no grant when idle.
    function automatic int ref_idx(input int r, input int w);
        for (int i = 0; i < w; i++) if (r[i]) return i;
        return 0;
    endfunction

    function automatic int ref_grant(input int r, input int w);
        return (r == 0) ? 0 : (1 << ref_idx(r, w));
    endfunction

    task automatic apply8(input int r);
        @(negedge clk);
        req8 = r[7:0];
        #1;
    endtask

    task automatic apply5(input int r);
        @(negedge clk);
        req5 = r[4:0];
        #1;
    endtask

    // Compare one form of width 8 against the reference.
    task automatic cmp8(input string nm, input int r, input logic [7:0] g,
                        input logic a, input logic [2:0] ix);
        int eg = ref_grant(r, 8);
        chk(g == eg[7:0], {"R1 grant ", nm}, g, eg);
        chk($countones(g) <= 1, {"R3 onehot ", nm}, $countones(g), 1);
        chk(a == (r != 0), {"R4 any ", nm}, a, r != 0);
        chk(int'(ix) == ref_idx(r, 8), {"R5 index ", nm}, ix, ref_idx(r, 8));
        if (r != 0) chk(g != 0, {"R7 granted ", nm}, g, eg);
    endtask

    task automatic test_reset_state();
        apply8(0);
        apply5(0);
        rst_n = 1'b1;
        chk(g_ch == 0 && g_ad == 0 && g_tr == 0, "R6 idle grant", {g_ch, g_ad, g_tr}, 0);
        chk(!a_ch && !a_ad && !a_tr, "R6 idle any", {a_ch, a_ad, a_tr}, 0);
        chk(i_ch == 0 && i_ad == 0 && i_tr == 0, "R6 idle index", {i_ch, i_ad, i_tr}, 0);
        chk(g5_ad == 0 && i5_tr == 0 && !a5_tr, "R6 idle width5", {g5_ad, i5_tr}, 0);
    endtask

    task automatic test_example();
        apply8(8'b01100100);
        chk(g_ch == 8'b00000100, "R2 chain grant", g_ch, 8'b00000100);
        chk(g_ad == 8'b00000100, "R2 adder grant", g_ad, 8'b00000100);
        chk(g_tr == 8'b00000100, "R2 tree grant", g_tr, 8'b00000100);
        chk(i_tr == 3'd2 && i_ad == 3'd2, "R2 index", i_tr, 2);
    endtask

    task automatic test_extremes();
        apply8(8'hFF);
        cmp8("all-on chain", 8'hFF, g_ch, a_ch, i_ch);
        cmp8("all-on tree", 8'hFF, g_tr, a_tr, i_tr);
        apply8(8'h80);
        cmp8("top-only adder", 8'h80, g_ad, a_ad, i_ad);
        cmp8("top-only tree", 8'h80, g_tr, a_tr, i_tr);
    endtask

    task automatic test_exhaustive8();
        for (int r = 0; r < 256; r++) begin
            apply8(r);
            cmp8("chain", r, g_ch, a_ch, i_ch);
            cmp8("adder", r, g_ad, a_ad, i_ad);
            cmp8("tree", r, g_tr, a_tr, i_tr);
            chk(g_ch == g_ad && g_ad == g_tr && i_ch == i_ad && i_ad == i_tr
                && a_ch == a_ad && a_ad == a_tr, "R8 forms agree", {g_ad, g_tr}, {g_ch, g_ch});
        end
    endtask

    task automatic test_width5();
        for (int r = 0; r < 32; r++) begin
            int eg;
            apply5(r);
            eg = ref_grant(r, 5);
            chk(g5_ch == eg[4:0], "R9 chain5 grant", g5_ch, eg);
            chk(g5_ad == eg[4:0], "R9 adder5 grant", g5_ad, eg);
            chk(g5_tr == eg[4:0], "R9 tree5 grant", g5_tr, eg);
            chk(int'(i5_tr) == ref_idx(r, 5) && int'(i5_ch) == ref_idx(r, 5),
                "R9 index5", i5_tr, ref_idx(r, 5));
            chk(a5_tr == (r != 0) && a5_ad == (r != 0), "R9 any5", a5_tr, r != 0);
        end
    endtask

    initial begin
        test_reset_state();
        test_example();
        test_extremes();
        test_exhaustive8();
        test_width5();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule